// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block is a serial slave on a two-wire bus (SCL clock, SDA data). It gives an external master byte-wide read and write access to a small bank of 8-bit control registers held inside the block. Both bus lines are brought into the system clock domain through a synchronizer chain. START and STOP conditions are recognised from the synchronized levels. The block answers only to one fixed 7-bit device address. It drives SDA only through an active-low, open-drain style enable.

A write transaction carries the device address with the direction bit low, then a sub-address byte, then any number of data bytes. The data bytes land in consecutive registers. A read transaction carries the device address with the direction bit high and has no address phase of its own. It returns register contents starting at the internal pointer, which the most recent write transaction left in place. The pointer steps after every byte, in both directions, and wraps from the top register back to register 0. A side read port lets neighbouring logic observe any register at any time.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset the SDA drive enable is low and every register reads 0 on the side port.
- R2: On the 9th clock of the first byte after START, the slave pulls SDA low (acknowledge) exactly when bits 7..1 of that byte equal the device address. Otherwise it never drives SDA and ignores all later bytes (no acknowledge, no register change) until the next START.
- R3: In a write transaction the first byte after the address byte becomes the register pointer (its low bits). Each later byte is stored at the pointer and acknowledged.
- R4: A read transaction (address byte bit 0 = 1) returns bytes starting at the pointer left by earlier traffic, with no sub-address byte.
- R5: The pointer advances by one after every data byte written and after every byte read. A new read with no write in between continues where the last transfer stopped.
- R6: The pointer wraps from the highest register (2^REG_AW - 1) to register 0.
- R7: When the master leaves SDA high in the acknowledge slot after a read byte, the slave stops driving SDA and stays silent until the next START.
- R8: A START or STOP seen at any bit position aborts the byte in progress without storing it. START begins a fresh address byte.
- R9: The SDA drive enable changes only while the synchronized SCL is low.
- R10: Bytes travel most significant bit first in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| rd_addr | input | REG_AW | Side read port register index |
| rd_data | output | 8 | Side read port register contents |

## Verification
The bench builds the slave with REG_AW = 3 and device address 7'h5A. With only eight registers, every start offset of a read burst can be swept, and every burst of nine bytes crosses the wrap point. With a 7-bit address space, all 128 addresses can be offered and only one of them must be acknowledged. Aborts by START and STOP in the middle of a byte, a wrong-address transaction followed by data, and a read that ends with no acknowledge are each driven as a dedicated sequence. The results are read back through the bus and through the side port.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_t;

    typedef enum logic [1:0] {
        BY_DEV,
        BY_SUB,
        BY_DATA
    } byte_kind_t;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    localparam int BYTE_BITS = 8;

    function automatic logic dev_hit(input logic [7:0] b, input logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_slv_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output logic    scl_lvl,
    output bus_ev_t ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[l]};
        end
        assign synced[l] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    assign scl_lvl     = synced[1];
    assign ev.sda      = synced[0];
    assign ev.scl_rise = synced[1] & ~prev[1];
    assign ev.scl_fall = ~synced[1] & prev[1];
    assign ev.start    = synced[1] & prev[1] & prev[0] & ~synced[0];
    assign ev.stop     = synced[1] & prev[1] & ~prev[0] & synced[0];
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/i2c_slv_fsm.sv
module i2c_slv_fsm
    import i2c_slv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         AW       = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic [7:0]    rd_byte,
    output logic          sda_oe,
    output logic [AW-1:0] ptr,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [7:0]    wdata,
    output phase_t        phase
);
    byte_kind_t kind;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic       rd_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            kind    <= BY_DEV;
            cnt     <= '0;
            shreg   <= '0;
            rd_mode <= 1'b0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            we      <= 1'b0;
            waddr   <= '0;
            wdata   <= '0;
        end else begin
            we <= 1'b0;
            if (ev.start) begin
                phase  <= PH_RX;
                kind   <= BY_DEV;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (phase)
                    PH_RX: begin
                        if (ev.scl_rise) begin
                            shreg <= {shreg[6:0], ev.sda};
                            cnt   <= cnt + 4'd1;
                        end else if (ev.scl_fall && cnt == 4'(BYTE_BITS)) begin
                            cnt <= '0;
                            unique case (kind)
                                BY_DEV: begin
                                    if (dev_hit(shreg, DEV_ADDR)) begin
                                        rd_mode <= shreg[0];
                                        kind    <= BY_SUB;
                                        sda_oe  <= 1'b1;
                                        phase   <= PH_RX_ACK;
                                    end else begin
                                        phase <= PH_IDLE;
                                    end
                                end
                                BY_SUB: begin
                                    ptr    <= shreg[AW-1:0];
                                    kind   <= BY_DATA;
                                    sda_oe <= 1'b1;
                                    phase  <= PH_RX_ACK;
                                end
                                default: begin
                                    we     <= 1'b1;
                                    waddr  <= ptr;
                                    wdata  <= shreg;
                                    ptr    <= ptr + 1'b1;
                                    sda_oe <= 1'b1;
                                    phase  <= PH_RX_ACK;
                                end
                            endcase
                        end
                    end
                    PH_RX_ACK: begin
                        if (ev.scl_fall) begin
                            cnt <= '0;
                            if (rd_mode) begin
                                shreg  <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                                phase  <= PH_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= PH_RX;
                            end
                        end
                    end
                    PH_TX: begin
                        if (ev.scl_fall) begin
                            if (cnt == 4'(BYTE_BITS - 1)) begin
                                sda_oe <= 1'b0;
                                ptr    <= ptr + 1'b1;
                                cnt    <= '0;
                                phase  <= PH_TX_ACK;
                            end else begin
                                sda_oe <= ~shreg[6];
                                shreg  <= {shreg[6:0], 1'b0};
                                cnt    <= cnt + 4'd1;
                            end
                        end
                    end
                    PH_TX_ACK: begin
                        if (ev.scl_rise && ev.sda) begin
                            phase <= PH_IDLE;
                        end else if (ev.scl_fall) begin
                            shreg  <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            phase  <= PH_TX;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_slv_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         REG_AW      = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    bus_ev_t           ev;
    logic              scl_lvl;
    logic [REG_AW-1:0] ptr;
    logic              reg_we;
    logic [REG_AW-1:0] reg_waddr;
    logic [7:0]        reg_wdata;
    logic [7:0]        cur_byte;
    phase_t            phase;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_lvl (scl_lvl),
        .ev      (ev)
    );

    i2c_slv_fsm #(.DEV_ADDR(DEV_ADDR), .AW(REG_AW)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_byte (cur_byte),
        .sda_oe  (sda_oe),
        .ptr     (ptr),
        .we      (reg_we),
        .waddr   (reg_waddr),
        .wdata   (reg_wdata),
        .phase   (phase)
    );

    i2c_reg_bank #(.AW(REG_AW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .waddr   (reg_waddr),
        .wdata   (reg_wdata),
        .raddr_a (ptr),
        .rdata_a (cur_byte),
        .raddr_b (rd_addr),
        .rdata_b (rd_data)
    );
endmodule

// File: rtl/i2c_slv_chk.sv
module i2c_slv_chk
    import i2c_slv_pkg::*;
#(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_lvl,
    input bus_ev_t       ev,
    input logic          sda_oe,
    input logic [AW-1:0] ptr,
    input logic          reg_we,
    input logic [AW-1:0] reg_waddr,
    input phase_t        phase
);
    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !sda_oe);

    p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

    p_write_step_r5: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> ptr == AW'(reg_waddr + 1'b1));

    p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_waddr == '1) |-> ptr == '0);

    p_idle_silent_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> !sda_oe);

    p_start_clears_r8: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (phase == PH_RX && !sda_oe));
endmodule

bind i2c_reg_slave i2c_slv_chk #(.AW(REG_AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_lvl   (scl_lvl),
    .ev        (ev),
    .sda_oe    (sda_oe),
    .ptr       (ptr),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .phase     (phase)
);

// File: tb/tb_i2c_reg_slave.sv
module tb_i2c_reg_slave;
    localparam logic [6:0] DEV = 7'h5A;
    localparam int AW    = 3;
    localparam int NREG  = 1 << AW;
    localparam int H     = 6;

    logic clk = 0;
    logic rst = 1;
    logic scl = 1;
    logic sda_m = 1;
    logic sda_oe;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0] rd_data;
    wire sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [7:0] model [NREG];

    always #5 clk = ~clk;

    i2c_reg_slave #(.DEV_ADDR(DEV), .REG_AW(AW)) dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (H) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1; hold(); scl = 1; hold(); sda_m = 0; hold(); scl = 0; hold();
    endtask

    task automatic bstop();
        sda_m = 0; hold(); scl = 1; hold(); sda_m = 1; hold();
    endtask

    task automatic wbit(input logic b);
        sda_m = b; hold(); scl = 1; hold(); scl = 0; hold();
    endtask

    task automatic rbit(output logic b);
        sda_m = 1; hold(); scl = 1; hold(); b = sda_line; scl = 0; hold();
    endtask

    task automatic wbyte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(a);
        ack = ~a;
    endtask

    task automatic rbyte(output logic [7:0] v, input logic last);
        logic b;
        for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
        wbit(last);
    endtask

    task automatic check_side(input string req);
        for (int i = 0; i < NREG; i++) begin
            rd_addr = AW'(i);
            @(negedge clk);
            chk(req, rd_data, model[i]);
        end
    endtask

    task automatic set_ptr(input int p);
        logic ack;
        bstart(); wbyte({DEV, 1'b0}, ack); wbyte(8'(p), ack); bstop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] v;
        logic b;
        int p;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 0;
        repeat (4) @(negedge clk);

        // R1: reset state
        chk("R1 sda_oe", sda_oe, 0);
        check_side("R1 reg");

        // R2: address sweep, only DEV acknowledged
        for (int a = 0; a < 128; a++) begin
            bstart(); wbyte({7'(a), 1'b0}, ack); bstop();
            chk("R2 addr ack", ack, (7'(a) == DEV));
        end

        // R3 R6 R10: write burst from 5 wrapping through all registers
        bstart(); wbyte({DEV, 1'b0}, ack); chk("R3 dev ack", ack, 1);
        wbyte(8'd5, ack); chk("R3 sub ack", ack, 1);
        for (int i = 0; i < NREG; i++) begin
            v = 8'(i * 37 + 11);
            wbyte(v, ack); chk("R3 data ack", ack, 1);
            model[(5 + i) % NREG] = v;
        end
        bstop();
        check_side("R3 R6 R10 stored");

        // R4 R5 R6 R10: read burst sweep over every start offset
        for (int s = 0; s < NREG; s++) begin
            set_ptr(s);
            bstart(); wbyte({DEV, 1'b1}, ack); chk("R4 rd ack", ack, 1);
            for (int k = 0; k < NREG + 1; k++) begin
                rbyte(v, k == NREG);
                chk("R4 R5 R6 read", v, model[(s + k) % NREG]);
            end
            bstop();
        end
        // R5: read with no write continues after last read (start 7, 9 bytes)
        bstart(); wbyte({DEV, 1'b1}, ack); rbyte(v, 1'b1); bstop();
        chk("R5 continue read", v, model[(7 + NREG + 1) % NREG]);

        // R5: write then read continues after the written bytes
        bstart(); wbyte({DEV, 1'b0}, ack); wbyte(8'd2, ack);
        wbyte(8'hA1, ack); wbyte(8'hB2, ack); bstop();
        model[2] = 8'hA1; model[3] = 8'hB2;
        bstart(); wbyte({DEV, 1'b1}, ack); rbyte(v, 1'b1); bstop();
        chk("R5 after write", v, model[4]);

        // R2: wrong address, later bytes ignored
        bstart(); wbyte({DEV ^ 7'h01, 1'b0}, ack); chk("R2 miss", ack, 0);
        wbyte(8'h01, ack); chk("R2 ignored sub", ack, 0);
        wbyte(8'hEE, ack); chk("R2 ignored data", ack, 0);
        bstop();
        check_side("R2 unchanged");
        bstart(); wbyte({DEV ^ 7'h40, 1'b1}, ack); chk("R2 rd miss", ack, 0);
        rbyte(v, 1'b1); chk("R2 no drive", v, 8'hFF);
        bstop();

        // R7: no acknowledge ends drive
        set_ptr(0);
        bstart(); wbyte({DEV, 1'b1}, ack); rbyte(v, 1'b1);
        chk("R7 byte", v, model[0]);
        p = 0;
        for (int i = 0; i < 9; i++) begin rbit(b); if (b) p++; end
        chk("R7 silent bits", p, 9);
        chk("R7 sda_oe", sda_oe, 0);
        bstop();

        // R8: repeated START inside a byte
        bstart(); wbit(1); wbit(0); wbit(1);
        bstart(); wbyte({DEV, 1'b0}, ack); chk("R8 restart ack", ack, 1);
        wbyte(8'd6, ack); wbyte(8'h3C, ack); bstop();
        model[6] = 8'h3C;
        // R8: STOP inside a data byte stores nothing
        bstart(); wbyte({DEV, 1'b0}, ack); wbyte(8'd1, ack);
        wbit(0); wbit(1); wbit(0); wbit(1);
        bstop();
        check_side("R8 abort");
        bstart(); wbyte({DEV, 1'b1}, ack); rbyte(v, 1'b1); bstop();
        chk("R8 ptr kept", v, model[1]);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule